// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers up to 32 interrupt sources into a single request line for a processor. Each source is synchronized and then latched into a status bit. Whether a source counts when it is high or only when it rises is fixed at build time by a per-source kind parameter. A per-source enable selects which latched bits become pending. A two-bit master control gates the request line.

Software reaches the controller through a plain word-wide register port, with an address, a write strobe with data, and a read strobe with registered read data. It can replace the whole enable mask or set or clear enable bits atomically. It clears latched status by writing a bit mask to the acknowledge word. It reads the lowest-numbered pending source from the vector word.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master control read 0, the vector word reads 0xFFFFFFFF and irq_out is low.
- R2: A level source (kind bit 0) that is high latches its status bit whether or not it is enabled, and the pending word (offset 0x04) reads status AND enable; status is at offset 0x00 and enable at 0x08.
- R3: An edge source (kind bit 1) sets its status bit only on a synchronized rising edge, and once acknowledged it stays clear while the source stays high.
- R4: A level source that is still high when acknowledged reads as set again immediately afterwards.
- R5: Writing a mask to the acknowledge word (0x0C) clears only the status bits that are 1 in the mask; 0xFFFFFFFF clears all of them.
- R6: Writing a mask to 0x10 sets only the masked enable bits, and writing a mask to 0x14 clears only the masked enable bits; every other enable bit keeps its value.
- R7: A write to 0x08 replaces the whole enable mask, so writing 0 disables every source.
- R8: The vector word (0x18) returns the index of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R9: irq_out is a register that is high one cycle after master bit 0 and master bit 1 (word 0x1C) are both 1 and at least one source is pending, and low otherwise.
- R10: The write-only words 0x0C, 0x10 and 0x14 read as 0. The master word reads back only bits [1:0]. Any access with addr[1:0] nonzero is ignored: the write has no effect and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Interrupt source lines |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rd_data is updated on the next edge |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check several rules. An acknowledge clears the masked status bits unless a new event arrives in the same cycle, and a new event always latches. Set-enable and clear-enable touch only the masked bits. The vector word always names a pending bit and reads all ones only when nothing is pending. The request line stays low without both master bits and rises only when something was pending. Only the bench scenarios can show the end-to-end latency through the synchronizer, the difference between a level source and an edge source after an acknowledge, the exact lowest-index choice among several pending sources, and the read values of the write-only and misaligned words.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RG_STAT  = 3'd0,
    RG_PEND  = 3'd1,
    RG_EN    = 3'd2,
    RG_ACK   = 3'd3,
    RG_SETEN = 3'd4,
    RG_CLREN = 3'd5,
    RG_VEC   = 3'd6,
    RG_MSTR  = 3'd7
  } reg_word_e;

  localparam logic [REG_W-1:0] VEC_NONE = {REG_W{1'b1}};

  // Index of the lowest set bit, VEC_NONE when the word is empty.
  function automatic logic [REG_W-1:0] lowest_set(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] idx;
    idx = VEC_NONE;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) idx = REG_W'(i);
    end
    return idx;
  endfunction

  // Next status word: acknowledge clears, a fresh event wins over it.
  function automatic logic [REG_W-1:0] status_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] ack,
                                                   input logic [REG_W-1:0] evt);
    return (cur & ~ack) | evt;
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int                 N_SRC     = 32,
  parameter logic [N_SRC-1:0]   EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] ack_mask,
  output logic [N_SRC-1:0] set_vec,
  output logic [N_SRC-1:0] status
);
  import irq_ctrl_pkg::*;

  logic [N_SRC-1:0] sync_a, sync_b, sync_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
    end else begin
      sync_a    <= src_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_kind
    if (EDGE_KIND[i]) begin : g_edge
      assign set_vec[i] = sync_b[i] & ~sync_prev[i];
    end else begin : g_level
      assign set_vec[i] = sync_b[i];
    end
  end

  logic [REG_W-1:0] stat_n;
  assign stat_n = status_next(REG_W'(status), REG_W'(ack_mask), REG_W'(set_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= stat_n[N_SRC-1:0];
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_set_wr,
  input  logic             en_clr_wr,
  input  logic             mstr_wr,
  input  logic [N_SRC-1:0] wr_mask,
  input  logic [1:0]       mstr_data,
  output logic [N_SRC-1:0] enable,
  output logic [1:0]       master
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      master <= '0;
    end else begin
      if (en_wr)          enable <= wr_mask;
      else if (en_set_wr) enable <= enable | wr_mask;
      else if (en_clr_wr) enable <= enable & ~wr_mask;
      if (mstr_wr)        master <= mstr_data;
    end
  end
endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0]                 pending,
  output logic [irq_ctrl_pkg::REG_W-1:0]   vec_idx
);
  import irq_ctrl_pkg::*;
  assign vec_idx = lowest_set(REG_W'(pending));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int               N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [4:0]       addr,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic             irq_out
);
  import irq_ctrl_pkg::*;

  reg_word_e        word;
  logic             aligned;
  logic             wr_ok;
  logic             en_wr, en_set_wr, en_clr_wr, mstr_wr, ack_wr;
  logic [N_SRC-1:0] wr_mask, ack_mask;
  logic [N_SRC-1:0] status, enable, pending, set_vec;
  logic [1:0]       master;
  logic             master_both;
  logic [REG_W-1:0] vec_idx;
  logic [REG_W-1:0] rd_mux;

  assign word      = reg_word_e'(addr[4:2]);
  assign aligned   = (addr[1:0] == 2'b00);
  assign wr_ok     = wr_en & aligned;
  assign wr_mask   = wr_data[N_SRC-1:0];
  assign en_wr     = wr_ok & (word == RG_EN);
  assign en_set_wr = wr_ok & (word == RG_SETEN);
  assign en_clr_wr = wr_ok & (word == RG_CLREN);
  assign mstr_wr   = wr_ok & (word == RG_MSTR);
  assign ack_wr    = wr_ok & (word == RG_ACK);
  assign ack_mask  = ack_wr ? wr_mask : '0;

  irq_src_capture #(.N_SRC(N_SRC), .EDGE_KIND(EDGE_KIND)) cap_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .ack_mask(ack_mask),
    .set_vec(set_vec), .status(status)
  );

  irq_cfg_regs #(.N_SRC(N_SRC)) cfg_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_set_wr(en_set_wr),
    .en_clr_wr(en_clr_wr), .mstr_wr(mstr_wr), .wr_mask(wr_mask),
    .mstr_data(wr_data[1:0]), .enable(enable), .master(master)
  );

  assign pending     = status & enable;
  assign master_both = master[0] & master[1];

  irq_vector_enc #(.N_SRC(N_SRC)) enc_i (.pending(pending), .vec_idx(vec_idx));

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (word)
        RG_STAT: rd_mux = REG_W'(status);
        RG_PEND: rd_mux = REG_W'(pending);
        RG_EN:   rd_mux = REG_W'(enable);
        RG_VEC:  rd_mux = vec_idx;
        RG_MSTR: rd_mux = REG_W'(master);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq_out <= master_both & (|pending);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] enable,
  input logic [N_SRC-1:0] pending,
  input logic [N_SRC-1:0] ack_mask,
  input logic [N_SRC-1:0] set_vec,
  input logic [N_SRC-1:0] wr_mask,
  input logic             en_set_wr,
  input logic             en_clr_wr,
  input logic [1:0]       master,
  input logic [31:0]      vec_idx,
  input logic             irq_out
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0) |=> ((status & $past(ack_mask) & ~$past(set_vec)) == '0));

  a_r6_set_masked: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_wr |=> ((enable & $past(wr_mask)) == $past(wr_mask)));

  a_r6_clr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_wr |=> ((enable & $past(wr_mask)) == '0));

  a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_wr | en_clr_wr) |=> ((enable & ~$past(wr_mask)) == ($past(enable) & ~$past(wr_mask))));

  a_r8_vec_names_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != 32'hFFFF_FFFF) |-> pending[vec_idx[IW-1:0]]);

  a_r8_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vec_idx == 32'hFFFF_FFFF));

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(master[0] & master[1]) |=> !irq_out);

  a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(pending != '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .status(status), .enable(enable), .pending(pending),
  .ack_mask(ack_mask), .set_vec(set_vec), .wr_mask(wr_mask),
  .en_set_wr(en_set_wr), .en_clr_wr(en_clr_wr), .master(master),
  .vec_idx(vec_idx), .irq_out(irq_out)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam int          N = 32;
  localparam logic [31:0] KIND = 32'hFFFF_0000;  // upper half edge, lower half level
  localparam logic [4:0]  A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                          A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MSTR = 5'h1C;

  typedef struct packed { logic [31:0] src; logic [31:0] en; } vec_t;
  localparam vec_t TBL [4] = '{
    '{src: 32'h0000_0001, en: 32'hFFFF_FFFF},
    '{src: 32'h0000_8004, en: 32'h0000_8000},
    '{src: 32'h0000_0F00, en: 32'h0000_0000},
    '{src: 32'h0000_00F0, en: 32'h0000_0060}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;
  int          total = 0, bad = 0;
  logic [31:0] r;

  always #4 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N), .EDGE_KIND(KIND)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [31:0] first_one(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  initial begin
    idle(200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    check("R1 irq", 32'(irq_out), 0);
    rd(A_STAT, r); check("R1 status", r, 0);
    rd(A_EN, r);   check("R1 enable", r, 0);
    rd(A_MSTR, r); check("R1 master", r, 0);
    rd(A_VEC, r);  check("R1 vector", r, 32'hFFFF_FFFF);

    // table of level-source patterns: R2 and R8
    foreach (TBL[k]) begin
      src_in = TBL[k].src; idle(4);
      wr(A_EN, TBL[k].en);
      rd(A_STAT, r); check("R2 status", r, TBL[k].src);
      rd(A_PEND, r); check("R2 pending", r, TBL[k].src & TBL[k].en);
      rd(A_VEC, r);  check("R8 vector", r, first_one(TBL[k].src & TBL[k].en));
      src_in = '0; idle(4);
      wr(A_ACK, 32'hFFFF_FFFF);
      rd(A_STAT, r); check("R5 ack all", r, 0);
    end

    // R5 partial acknowledge
    src_in = 32'h0000_0003; idle(4); src_in = '0; idle(4);
    wr(A_ACK, 32'h0000_0001);
    rd(A_STAT, r); check("R5 partial", r, 32'h0000_0002);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R4 level held through acknowledge
    src_in = 32'h0000_0010; idle(4);
    wr(A_ACK, 32'h0000_0010);
    rd(A_STAT, r); check("R4 relatch", r, 32'h0000_0010);
    src_in = '0; idle(4); wr(A_ACK, 32'hFFFF_FFFF);

    // R3 edge source held high
    src_in = 32'h0001_0000; idle(4);
    rd(A_STAT, r); check("R3 edge latched", r, 32'h0001_0000);
    wr(A_ACK, 32'h0001_0000); idle(4);
    rd(A_STAT, r); check("R3 no relatch", r, 0);
    src_in = '0; idle(4);
    src_in = 32'h0001_0000; idle(4);
    rd(A_STAT, r); check("R3 second edge", r, 32'h0001_0000);
    src_in = '0; wr(A_ACK, 32'hFFFF_FFFF);

    // R6 set/clear enable, R7 full write
    wr(A_EN, 32'h0000_000F);
    wr(A_SET, 32'h0000_0030);
    rd(A_EN, r); check("R6 set", r, 32'h0000_003F);
    wr(A_CLR, 32'h0000_0005);
    rd(A_EN, r); check("R6 clear", r, 32'h0000_003A);
    wr(A_EN, 32'h0000_0000);
    rd(A_EN, r); check("R7 zero", r, 0);

    // R9 master gating
    src_in = 32'h0000_0008; idle(4);
    wr(A_EN, 32'h0000_0008);
    wr(A_MSTR, 32'h1); idle(1);
    check("R9 one bit", 32'(irq_out), 0);
    wr(A_MSTR, 32'h3); idle(1);
    check("R9 both", 32'(irq_out), 1);
    wr(A_MSTR, 32'h2); idle(1);
    check("R9 hie only", 32'(irq_out), 0);
    wr(A_MSTR, 32'h3); wr(A_EN, 32'h0); idle(1);
    check("R9 none pending", 32'(irq_out), 0);

    // R10 readback rules
    wr(A_MSTR, 32'hFFFF_FFFF);
    rd(A_MSTR, r); check("R10 master bits", r, 32'h3);
    wr(A_SET, 32'h0000_0100);
    rd(A_ACK, r); check("R10 ack reads 0", r, 0);
    rd(A_SET, r); check("R10 set reads 0", r, 0);
    rd(A_CLR, r); check("R10 clr reads 0", r, 0);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(A_EN, r); check("R10 misaligned write", r, 32'h0000_0100);
    rd(5'h0A, r); check("R10 misaligned read", r, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule